// File: doc/BRIEF.md
# Sound Interrupt Status and Mask Controller

This block merges interrupt requests from a bank of PCM playback channels and from one FM synthesis source onto a single interrupt line. Software sees three byte-wide registers through a simple address / strobe port: a per-channel enable mask, a per-channel status register that empties itself when read, and a read-only reason register that tells the handler which kind of source is pending.

Channel events arrive on an indexed event port. Each event either sets or clears one channel's status bit, or, with the all-channels flag, forces every status bit to the same level. Status bits record events whatever the mask holds. The mask only decides whether a set event may raise the line. The line register also records which source raised the line last. That record decides whether a later FM drop or a PCM clear may lower the line, and whether a status read also retires the FM flag.

Top module: `snd_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, the status register and the FM flag are zero, every implemented mask bit is one, and the read data is zero.
- R2: The mask register at word address 0x04ea reads and writes whole, one bit per channel in bits NUM_CH-1:0. A 1 lets that channel raise the line.
- R3: Reading the reason register at 0x04e9 returns bit 3 set when any status bit is set and bit 0 set when the FM flag is set. All other bits read as zero.
- R4: Reading the status register at 0x04eb returns the status bits and then clears all of them. If the line is asserted at that moment, the read also clears the FM flag and lowers the line.
- R5: A single-channel event (evt_all=0) with evt_set=1 sets the status bit of channel evt_ch, and raises the line when that channel's mask bit is 1.
- R6: A single-channel clear (evt_set=0), or a set on a channel whose mask bit is 0, writes the status bit and lowers the line unless the FM flag is set. The status bit is written even when the channel is masked.
- R7: An all-channels event (evt_all=1) forces every status bit to evt_set, and only when this changes the status value. A set raises the line if any mask bit is 1. A clear lowers the line unless the FM flag is set. An event that leaves the status unchanged changes nothing.
- R8: A rising FM level sets the FM flag and raises the line. A falling FM level clears the FM flag and lowers the line if it was raised, even when PCM status bits remain set.
- R9: A channel event in the same cycle as a status read is held for one cycle. The read returns the status from before the event, and the event is applied on the next clock edge.
- R10: Read data is registered: it is valid in the cycle after the read strobe and zero in any cycle that follows no read. Reads from any other address return zero.
- R11: Writes to the status and reason addresses change neither the status, the FM flag nor the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| evt_vld | input | 1 | Channel event valid this cycle |
| evt_ch | input | CH_W | Channel index of a single-channel event |
| evt_set | input | 1 | Event level: 1 sets, 0 clears |
| evt_all | input | 1 | Event applies to every channel |
| fm_level | input | 1 | FM source interrupt level |
| irq_out | output | 1 | Merged interrupt line |

## Verification
The bench builds the block with its defaults: eight channels, 16-bit addresses and byte data, which makes the full-width mask and status patterns (0xff, 0x5a) reachable. The register addresses stay at their default word values, so the unmapped-address checks cover both a neighbouring word and an address that matches only in its low byte. With eight channels every status bit has a position of its own in the byte. A wrong bit lane, an all-channels pattern that does not fill the byte, or the reason bit 3 landing on a channel's bit shows up as a different read value.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;

  // bit positions inside the reason register
  localparam int unsigned RSN_PCM_BIT = 3;
  localparam int unsigned RSN_FM_BIT  = 0;

  // one channel event as seen by the core
  typedef struct packed {
    logic       vld;
    logic       all;
    logic       set;
    logic [7:0] ch;
  } snd_evt_t;

endpackage

// File: rtl/snd_irq_regs.sv
module snd_irq_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 8,
  parameter logic [ADDR_W-1:0] RSN_ADDR  = 16'h04e9,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h04ea,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h04eb
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [NUM_CH-1:0] status_i,
  input  logic              fm_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic              rd_stat_o,
  output logic [DATA_W-1:0] rdata_o
);
  import snd_irq_pkg::*;

  logic              hit_rsn, hit_mask, hit_stat;
  logic [NUM_CH-1:0] mask_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  function automatic logic [DATA_W-1:0] f_widen(logic [NUM_CH-1:0] bits);
    logic [DATA_W-1:0] v;
    v = '0;
    v[NUM_CH-1:0] = bits;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] f_reason(logic [NUM_CH-1:0] st, logic fm);
    logic [DATA_W-1:0] v;
    v = '0;
    v[RSN_PCM_BIT] = |st;
    v[RSN_FM_BIT]  = fm;
    return v;
  endfunction

  assign hit_rsn  = (reg_addr == RSN_ADDR);
  assign hit_mask = (reg_addr == MASK_ADDR);
  assign hit_stat = (reg_addr == STAT_ADDR);

  always_comb begin
    rdata_d = '0;
    if (reg_rd) begin
      if (hit_rsn)       rdata_d = f_reason(status_i, fm_i);
      else if (hit_mask) rdata_d = f_widen(mask_q);
      else if (hit_stat) rdata_d = f_widen(status_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
      if (reg_wr && hit_mask) mask_q <= reg_wdata[NUM_CH-1:0];
    end
  end

  assign mask_o    = mask_q;
  assign rd_stat_o = reg_rd && hit_stat;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/snd_irq_core.sv
module snd_irq_core #(
  parameter int NUM_CH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  snd_irq_pkg::snd_evt_t ev_in,
  input  logic                  rd_stat,
  input  logic [NUM_CH-1:0]     mask,
  input  logic                  fm_level,
  output logic [NUM_CH-1:0]     status_o,
  output logic                  fm_flag_o,
  output logic                  line_o,
  output logic                  pend_vld_o,
  output logic                  ev_raise_o,
  output logic                  ev_applied_o,
  output logic                  fm_rise_o
);
  import snd_irq_pkg::*;

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef struct packed {
    logic [NUM_CH-1:0] status;
    logic              fm;
    logic              line;   // doubles as the "last raised by" record
  } core_st_t;

  core_st_t st_q, st_rd, st_pend, st_new, st_d;
  snd_evt_t pend_q, pend_d;
  logic     fm_prev_q, fm_rise, fm_fall, new_apply;

  function automatic logic f_in_range(snd_evt_t e);
    return (32'(e.ch) < 32'(NUM_CH));
  endfunction

  // status read: empty the status, retire the last raiser
  function automatic core_st_t f_read_clear(core_st_t s);
    core_st_t r;
    r = s;
    r.status = '0;
    if (s.line) begin
      r.fm   = 1'b0;
      r.line = 1'b0;
    end
    return r;
  endfunction

  function automatic core_st_t f_apply(core_st_t s, snd_evt_t e, logic [NUM_CH-1:0] m);
    core_st_t          r;
    logic [NUM_CH-1:0] fill;
    logic [CH_W-1:0]   idx;
    r    = s;
    fill = e.set ? '1 : '0;
    idx  = e.ch[CH_W-1:0];
    if (e.all) begin
      if (fill != s.status) begin
        r.status = fill;
        if (e.set) begin
          if ((fill & m) != '0) r.line = 1'b1;
        end else if (!s.fm) begin
          r.line = 1'b0;
        end
      end
    end else if (f_in_range(e)) begin
      r.status[idx] = e.set;
      if (e.set && m[idx]) r.line = 1'b1;
      else if (!s.fm)      r.line = 1'b0;
    end
    return r;
  endfunction

  function automatic core_st_t f_fm(core_st_t s, logic rise, logic fall);
    core_st_t r;
    r = s;
    if (rise) begin
      r.fm   = 1'b1;
      r.line = 1'b1;
    end else if (fall) begin
      r.fm = 1'b0;
      if (s.line) r.line = 1'b0;
    end
    return r;
  endfunction

  function automatic logic f_can_raise(snd_evt_t e, logic [NUM_CH-1:0] m);
    logic [CH_W-1:0] idx;
    idx = e.ch[CH_W-1:0];
    if (!e.vld || !e.set) return 1'b0;
    if (e.all)            return |m;
    return f_in_range(e) && m[idx];
  endfunction

  assign fm_rise   = fm_level && !fm_prev_q;
  assign fm_fall   = !fm_level && fm_prev_q;
  assign new_apply = ev_in.vld && !rd_stat;

  // order inside one cycle: read, held event, new event, FM edge
  always_comb begin
    st_rd   = rd_stat ? f_read_clear(st_q) : st_q;
    st_pend = pend_q.vld ? f_apply(st_rd, pend_q, mask) : st_rd;
    st_new  = new_apply ? f_apply(st_pend, ev_in, mask) : st_pend;
    st_d    = f_fm(st_new, fm_rise, fm_fall);
    pend_d  = (ev_in.vld && rd_stat) ? ev_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      pend_q    <= '0;
      fm_prev_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      pend_q    <= pend_d;
      fm_prev_q <= fm_level;
    end
  end

  assign status_o     = st_q.status;
  assign fm_flag_o    = st_q.fm;
  assign line_o       = st_q.line;
  assign pend_vld_o   = pend_q.vld;
  assign ev_raise_o   = f_can_raise(pend_q, mask) || (new_apply && f_can_raise(ev_in, mask));
  assign ev_applied_o = pend_q.vld || new_apply;
  assign fm_rise_o    = fm_rise;

endmodule

// File: rtl/snd_irq_ctrl.sv
module snd_irq_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 8,
  parameter logic [ADDR_W-1:0] RSN_ADDR  = 16'h04e9,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h04ea,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h04eb,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_vld,
  input  logic [CH_W-1:0]   evt_ch,
  input  logic              evt_set,
  input  logic              evt_all,
  input  logic              fm_level,
  output logic              irq_out
);
  import snd_irq_pkg::*;

  // named internal events, observed by the bound checker
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] status_q;
  logic              fm_flag;
  logic              rd_stat_hit;
  logic              pend_vld;
  logic              ev_raise;
  logic              ev_applied;
  logic              fm_rise_w;
  snd_evt_t          ev_in;

  always_comb begin
    ev_in     = '0;
    ev_in.vld = evt_vld;
    ev_in.all = evt_all;
    ev_in.set = evt_set;
    ev_in.ch  = 8'(evt_ch);
  end

  snd_irq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
    .RSN_ADDR(RSN_ADDR), .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .status_i  (status_q),
    .fm_i      (fm_flag),
    .mask_o    (mask_q),
    .rd_stat_o (rd_stat_hit),
    .rdata_o   (reg_rdata)
  );

  snd_irq_core #(.NUM_CH(NUM_CH)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_in        (ev_in),
    .rd_stat      (rd_stat_hit),
    .mask         (mask_q),
    .fm_level     (fm_level),
    .status_o     (status_q),
    .fm_flag_o    (fm_flag),
    .line_o       (irq_out),
    .pend_vld_o   (pend_vld),
    .ev_raise_o   (ev_raise),
    .ev_applied_o (ev_applied),
    .fm_rise_o    (fm_rise_w)
  );

endmodule

// File: rtl/snd_irq_chk.sv
module snd_irq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 8,
  parameter logic [ADDR_W-1:0] RSN_ADDR  = 16'h04e9,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h04ea,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h04eb
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              evt_vld,
  input logic              fm_level,
  input logic              irq_out,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] status_q,
  input logic              rd_stat_hit,
  input logic              pend_vld,
  input logic              ev_raise,
  input logic              ev_applied,
  input logic              fm_rise_w
);
  logic mapped;
  assign mapped = (reg_addr == RSN_ADDR) || (reg_addr == MASK_ADDR) || (reg_addr == STAT_ADDR);

  AST_MASK_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == MASK_ADDR) |=> mask_q == $past(reg_wdata[NUM_CH-1:0])); // R2

  AST_REASON_PCM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (reg_addr == RSN_ADDR) |=> reg_rdata[3] == ($past(status_q) != '0)); // R3

  AST_REASON_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (reg_addr == RSN_ADDR) |=> reg_rdata[2:1] == 2'b00 && reg_rdata[DATA_W-1:4] == '0); // R3

  AST_STATUS_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_hit && !pend_vld |=> status_q == '0); // R4

  AST_STATUS_READ_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_hit && !pend_vld && !fm_rise_w && irq_out |=> !irq_out); // R4

  AST_RAISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(ev_raise || fm_rise_w)); // R5

  AST_STATUS_SET_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~$past(status_q)) != '0 |-> $past(ev_applied)); // R7

  AST_FM_RISE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fm_level) |=> irq_out); // R8

  AST_READ_DEFERS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_hit && evt_vld |=> pend_vld); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !mapped |=> reg_rdata == '0); // R10

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == '0); // R10

endmodule

bind snd_irq_ctrl snd_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
  .RSN_ADDR(RSN_ADDR), .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata),
  .evt_vld     (evt_vld),
  .fm_level    (fm_level),
  .irq_out     (irq_out),
  .mask_q      (mask_q),
  .status_q    (status_q),
  .rd_stat_hit (rd_stat_hit),
  .pend_vld    (pend_vld),
  .ev_raise    (ev_raise),
  .ev_applied  (ev_applied),
  .fm_rise_w   (fm_rise_w)
);

// File: tb/test_snd_irq_ctrl.sv
module test_snd_irq_ctrl;

  localparam logic [15:0] A_RSN  = 16'h04e9;
  localparam logic [15:0] A_MASK = 16'h04ea;
  localparam logic [15:0] A_STAT = 16'h04eb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        evt_vld = 1'b0;
  logic [2:0]  evt_ch = '0;
  logic        evt_set = 1'b0;
  logic        evt_all = 1'b0;
  logic        fm_level = 1'b0;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  snd_irq_ctrl i_snd_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_vld(evt_vld), .evt_ch(evt_ch), .evt_set(evt_set), .evt_all(evt_all),
    .fm_level(fm_level), .irq_out(irq_out)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // all helpers start and end at a falling edge
  task automatic wr(logic [15:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic evt(logic [2:0] ch, logic set, logic all);
    evt_vld = 1'b1; evt_ch = ch; evt_set = set; evt_all = all;
    @(negedge clk);
    evt_vld = 1'b0; evt_all = 1'b0;
  endtask

  task automatic fm(logic lvl);
    fm_level = lvl;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1", "irq after reset", int'(irq_out), 0);
    chk("R1", "rdata after reset", int'(reg_rdata), 0);
    rd(A_MASK, d); chk("R1", "mask reset", int'(d), 8'hff);
    rd(A_STAT, d); chk("R1", "status reset", int'(d), 0);
    rd(A_RSN, d);  chk("R1", "reason reset (fm flag)", int'(d), 0);
  endtask

  task automatic t_mask_rw;
    logic [7:0] d;
    wr(A_MASK, 8'h5a); rd(A_MASK, d); chk("R2", "mask readback 5a", int'(d), 8'h5a);
    wr(A_MASK, 8'h00); rd(A_MASK, d); chk("R2", "mask readback 00", int'(d), 8'h00);
    wr(A_MASK, 8'hff);
  endtask

  task automatic t_single_set;
    logic [7:0] d;
    evt(3'd2, 1'b1, 1'b0);
    chk("R5", "irq after unmasked set", int'(irq_out), 1);
    rd(A_RSN, d);  chk("R3", "reason pcm bit", int'(d), 8'h08);
    rd(A_STAT, d); chk("R4", "status read value", int'(d), 8'h04);
    chk("R4", "irq after status read", int'(irq_out), 0);
    rd(A_STAT, d); chk("R4", "status emptied", int'(d), 0);
  endtask

  task automatic t_masked_and_clear;
    logic [7:0] d;
    wr(A_MASK, 8'hfe);
    evt(3'd0, 1'b1, 1'b0);
    chk("R6", "irq after masked set", int'(irq_out), 0);
    rd(A_STAT, d); chk("R6", "masked channel still latched", int'(d), 8'h01);
    fm(1'b1);
    chk("R8", "irq after fm rise", int'(irq_out), 1);
    rd(A_RSN, d); chk("R3", "reason fm bit", int'(d), 8'h01);
    evt(3'd1, 1'b0, 1'b0);
    chk("R6", "clear keeps line while fm active", int'(irq_out), 1);
    rd(A_STAT, d);
    chk("R4", "status read drops fm-raised line", int'(irq_out), 0);
    rd(A_RSN, d); chk("R4", "fm flag cleared by status read", int'(d), 0);
    fm(1'b0);
    chk("R8", "fm fall keeps line low", int'(irq_out), 0);
    wr(A_MASK, 8'hff);
  endtask

  task automatic t_all_channels;
    logic [7:0] d;
    wr(A_MASK, 8'h00);
    evt(3'd0, 1'b1, 1'b1);
    chk("R7", "all-set fully masked irq", int'(irq_out), 0);
    rd(A_RSN, d); chk("R7", "all-set latched reason", int'(d), 8'h08);
    wr(A_MASK, 8'h10);
    evt(3'd0, 1'b1, 1'b1);
    chk("R7", "unchanged all-set no effect", int'(irq_out), 0);
    evt(3'd0, 1'b0, 1'b1);
    rd(A_RSN, d); chk("R7", "all-clear empties status", int'(d), 0);
    evt(3'd0, 1'b1, 1'b1);
    chk("R7", "all-set with one unmasked", int'(irq_out), 1);
    rd(A_STAT, d); chk("R7", "all-set pattern", int'(d), 8'hff);
    wr(A_MASK, 8'hff);
  endtask

  task automatic t_fm_over_pcm;
    logic [7:0] d;
    evt(3'd3, 1'b1, 1'b0);
    fm(1'b1);
    rd(A_RSN, d); chk("R8", "reason both sources", int'(d), 8'h09);
    fm(1'b0);
    chk("R8", "fm fall drops line despite pcm", int'(irq_out), 0);
    rd(A_RSN, d); chk("R8", "pcm status survives fm fall", int'(d), 8'h08);
    rd(A_STAT, d); chk("R8", "status after fm fall", int'(d), 8'h08);
  endtask

  task automatic t_read_vs_event;
    logic [7:0] d;
    evt(3'd5, 1'b1, 1'b0);
    reg_addr = A_STAT; reg_rd = 1'b1;
    evt_vld = 1'b1; evt_ch = 3'd6; evt_set = 1'b1; evt_all = 1'b0;
    @(negedge clk);
    reg_rd = 1'b0; evt_vld = 1'b0;
    chk("R9", "read returns pre-event status", int'(reg_rdata), 8'h20);
    chk("R9", "line low in read cycle", int'(irq_out), 0);
    @(negedge clk);
    chk("R9", "held event raises next cycle", int'(irq_out), 1);
    rd(A_STAT, d); chk("R9", "held event latched", int'(d), 8'h40);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    evt(3'd7, 1'b1, 1'b0);
    rd(16'h04ec, d); chk("R10", "unmapped word", int'(d), 0);
    rd(16'h00e9, d); chk("R10", "low-byte alias", int'(d), 0);
    rd(A_RSN, d);    chk("R10", "reason registered", int'(d), 8'h08);
    @(negedge clk);  chk("R10", "rdata zero after idle cycle", int'(reg_rdata), 0);
    rd(A_STAT, d);
  endtask

  task automatic t_ignored_writes;
    logic [7:0] d;
    evt(3'd1, 1'b1, 1'b0);
    wr(A_STAT, 8'h00);
    wr(A_RSN, 8'h00);
    chk("R11", "line after ignored writes", int'(irq_out), 1);
    rd(A_STAT, d); chk("R11", "status after ignored writes", int'(d), 8'h02);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_single_set();
    t_masked_and_clear();
    t_all_channels();
    t_fm_over_pcm();
    t_read_vs_event();
    t_unmapped();
    t_ignored_writes();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule